// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block is the storage stage of one programmable-logic macrocell. It takes the data bit from the product-term allocator and presents Q to the feedback and output routing. Static configuration bits set how it stores that bit: as an edge-triggered D register, an edge-triggered T register, a level-sensitive D latch, or a combinational pass-through. A separate mode bit decides where the clock and the initialization come from. In synchronous mode the clock is one of four block clocks, and the block-wide reset and preset product terms drive initialization. In asynchronous mode the cell's own product-term clock is used, and one private product term acts as either reset or preset.

All clock and latch-enable inputs are level signals that are sampled on the system clock `clk`. An active edge is detected when the sampled, polarity-adjusted enable goes from inactive to active between two consecutive samples. Reset and preset requests are also sampled and take effect at the next `clk` edge. The power-up reset is the synchronous active-low `rst_n`. The configuration must not change except while `rst_n` is low.

Top module: `mc_storage_cell`

## Requirements
- R1: While `rst_n` is low, Q loads the power-up value and the enable history is cleared to inactive. The power-up value is 1 when `cfg_swap`=1 in synchronous mode (`cfg_async`=0), and 0 in every other case.
- R2: In synchronous mode the clock level is `blk_clk[cfg_blk_clk_sel]`. The other three block clocks have no effect.
- R3: In asynchronous mode (`cfg_async`=1) the clock level is `pt_clk`. In both modes, `cfg_clk_inv`=1 inverts the sampled level before edge detection and latch gating.
- R4: `cfg_kind`=2'b00 (D register) loads `d_in` at every active edge and holds otherwise. The new Q appears on `q_out` right after the `clk` edge at which the active edge was sampled.
- R5: `cfg_kind`=2'b01 (T register) inverts Q at an active edge when `d_in`=1 and holds when `d_in`=0.
- R6: `cfg_kind`=2'b10 (D latch) loads `d_in` at every `clk` edge at which the enable is sampled active, and holds while it is inactive.
- R7: In latch kind, the reset and preset requests from any source have no effect on Q.
- R8: `cfg_kind`=2'b11 (combinational) drives `q_out` equal to `d_in` in the same cycle, in either mode.
- R9: In synchronous register kinds, `blk_rst_pt`=1 forces Q to 0 and `blk_pre_pt`=1 forces Q to 1 at the next `clk` edge. `cfg_swap`=1 exchanges the roles of the two terms.
- R10: In asynchronous register kinds, `ind_init_pt`=1 forces Q to 1 when `cfg_init_is_preset`=1 and to 0 otherwise. The block reset and preset terms are ignored in this mode.
- R11: When the effective reset and preset are both active, reset wins and Q becomes 0. Either request overrides a clock edge sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Power-up reset, synchronous, active low |
| cfg_async | input | 1 | 0 = synchronous mode, 1 = asynchronous mode |
| cfg_kind | input | 2 | Storage type: 00 D reg, 01 T reg, 10 latch, 11 combinational |
| cfg_blk_clk_sel | input | 2 | Block clock index used in synchronous mode |
| cfg_clk_inv | input | 1 | Inverts clock / latch-enable polarity |
| cfg_swap | input | 1 | Exchanges block reset and preset, and the power-up value |
| cfg_init_is_preset | input | 1 | Asynchronous mode: private init term acts as preset |
| blk_clk | input | 4 | Block clock levels |
| pt_clk | input | 1 | Private product-term clock level |
| blk_rst_pt | input | 1 | Block-wide reset product term |
| blk_pre_pt | input | 1 | Block-wide preset product term |
| ind_init_pt | input | 1 | Private initialization product term |
| d_in | input | 1 | Data from the allocator |
| q_out | output | 1 | Stored or passed-through value |

## Verification
The bound checker checks these properties on every cycle: reset dominance, swapped and unswapped preset forcing, forcing from the private init term, latch and T-register hold when nothing should move, the combinational path, and the power-up value when reset is released. Correct loads on edges, the choice of clock source and polarity, and latch transparency all depend on the history of the sampled enable. Only the bench's behavioural model shows these, because it tracks every clock against randomized block clocks, product-term clocks and sparse initialization pulses in each configuration.

// File: rtl/mc_cell_pkg.sv
// Package: shared types for the macrocell storage cell.
// Assumes: storage kind encoding is fixed and visible at the top ports.
package mc_cell_pkg;

    typedef enum logic [1:0] {
        KIND_DREG  = 2'b00,
        KIND_TREG  = 2'b01,
        KIND_LATCH = 2'b10,
        KIND_COMB  = 2'b11
    } store_kind_e;

    typedef struct packed {
        logic force_lo;
        logic force_hi;
    } init_req_t;

endpackage

// File: rtl/mc_clk_pick.sv
// Module: mc_clk_pick
// Picks the clock source for the cell (block clock or private term),
// applies polarity and produces the sampled level and an active-edge pulse.
// Assumes: all clock inputs are levels sampled on clk; config is static.
module mc_clk_pick #(
    parameter int NUM_BLK_CLK = 4,
    localparam int SEL_W = (NUM_BLK_CLK > 1) ? $clog2(NUM_BLK_CLK) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_BLK_CLK-1:0] blk_clk,
    input  logic                   pt_clk,
    input  logic [SEL_W-1:0]       sel,
    input  logic                   use_pt,
    input  logic                   invert,
    output logic                   en_level,
    output logic                   en_edge
);

    logic raw_level;
    logic prev_level;

    // Source selection and polarity adjustment.
    always_comb begin
        raw_level = use_pt ? pt_clk : blk_clk[sel];
        en_level  = raw_level ^ invert;
    end

    // Remembers the previous sampled enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_level <= 1'b0;
        end else begin
            prev_level <= en_level;
        end
    end

    // Active edge: inactive sample followed by active sample.
    assign en_edge = en_level & ~prev_level;

endmodule

// File: rtl/mc_init_route.sv
// Module: mc_init_route
// Routes the initialization product terms into force-low / force-high
// requests according to mode, swap and the private-term role, and
// gives the power-up value.
// Assumes: purely combinational; dominance is resolved by the core.
module mc_init_route
    import mc_cell_pkg::*;
(
    input  logic      async_mode,
    input  logic      swap,
    input  logic      init_is_preset,
    input  logic      blk_rst,
    input  logic      blk_pre,
    input  logic      ind_init,
    output init_req_t req,
    output logic      pu_value
);

    // Selects the reset and preset sources for the current mode.
    always_comb begin
        if (async_mode) begin
            req.force_lo = ind_init & ~init_is_preset;
            req.force_hi = ind_init &  init_is_preset;
        end else if (swap) begin
            req.force_lo = blk_pre;
            req.force_hi = blk_rst;
        end else begin
            req.force_lo = blk_rst;
            req.force_hi = blk_pre;
        end
    end

    // Power-up state follows swap in synchronous mode only.
    assign pu_value = swap & ~async_mode;

endmodule

// File: rtl/mc_store_core.sv
// Module: mc_store_core
// Holds the state bit and applies the D, T or latch update rule,
// with reset dominating preset for the register kinds.
// Assumes: en_level/en_edge come from mc_clk_pick; kind is static.
module mc_store_core
    import mc_cell_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  store_kind_e kind,
    input  logic        d,
    input  logic        en_level,
    input  logic        en_edge,
    input  init_req_t   req,
    input  logic        pu_value,
    output logic        state
);

    logic next_state;

    // Next-state rule per storage kind.
    always_comb begin
        next_state = state;
        unique case (kind)
            KIND_LATCH: begin
                if (en_level) next_state = d;
            end
            KIND_COMB: begin
                next_state = state;
            end
            default: begin
                if (req.force_lo) begin
                    next_state = 1'b0;
                end else if (req.force_hi) begin
                    next_state = 1'b1;
                end else if (en_edge) begin
                    next_state = (kind == KIND_TREG) ? (state ^ d) : d;
                end
            end
        endcase
    end

    // State register with power-up load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= pu_value;
        end else begin
            state <= next_state;
        end
    end

endmodule

// File: rtl/mc_storage_cell.sv
// Module: mc_storage_cell (top)
// One macrocell storage element: D reg, T reg, D latch or combinational,
// in synchronous or asynchronous mode.
// Assumes: configuration changes only under rst_n low; clocks are levels
// sampled on clk.
module mc_storage_cell
    import mc_cell_pkg::*;
#(
    parameter int NUM_BLK_CLK = 4,
    localparam int SEL_W = (NUM_BLK_CLK > 1) ? $clog2(NUM_BLK_CLK) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_async,
    input  logic [1:0]             cfg_kind,
    input  logic [SEL_W-1:0]       cfg_blk_clk_sel,
    input  logic                   cfg_clk_inv,
    input  logic                   cfg_swap,
    input  logic                   cfg_init_is_preset,
    input  logic [NUM_BLK_CLK-1:0] blk_clk,
    input  logic                   pt_clk,
    input  logic                   blk_rst_pt,
    input  logic                   blk_pre_pt,
    input  logic                   ind_init_pt,
    input  logic                   d_in,
    output logic                   q_out
);

    store_kind_e kind;
    logic        en_level;
    logic        en_edge;
    init_req_t   req;
    logic        pu_value;
    logic        state;

    assign kind = store_kind_e'(cfg_kind);

    mc_clk_pick #(.NUM_BLK_CLK(NUM_BLK_CLK)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_clk  (blk_clk),
        .pt_clk   (pt_clk),
        .sel      (cfg_blk_clk_sel),
        .use_pt   (cfg_async),
        .invert   (cfg_clk_inv),
        .en_level (en_level),
        .en_edge  (en_edge)
    );

    mc_init_route u_init (
        .async_mode     (cfg_async),
        .swap           (cfg_swap),
        .init_is_preset (cfg_init_is_preset),
        .blk_rst        (blk_rst_pt),
        .blk_pre        (blk_pre_pt),
        .ind_init       (ind_init_pt),
        .req            (req),
        .pu_value       (pu_value)
    );

    mc_store_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .d        (d_in),
        .en_level (en_level),
        .en_edge  (en_edge),
        .req      (req),
        .pu_value (pu_value),
        .state    (state)
    );

    // Output: bypass in combinational kind, stored bit otherwise.
    assign q_out = (kind == KIND_COMB) ? d_in : state;

endmodule

// File: rtl/mc_storage_chk.sv
// Module: mc_storage_chk
// Port-level properties of mc_storage_cell, attached by bind below.
// Assumes: default parameter (4 block clocks).
module mc_storage_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_async,
    input logic [1:0] cfg_kind,
    input logic [1:0] cfg_blk_clk_sel,
    input logic       cfg_clk_inv,
    input logic       cfg_swap,
    input logic       cfg_init_is_preset,
    input logic [3:0] blk_clk,
    input logic       pt_clk,
    input logic       blk_rst_pt,
    input logic       blk_pre_pt,
    input logic       ind_init_pt,
    input logic       d_in,
    input logic       q_out
);

    logic is_reg;
    assign is_reg = (cfg_kind == 2'b00) || (cfg_kind == 2'b01);

    // R1: value right after power-up release
    p_powerup_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && cfg_kind != 2'b11) |-> (q_out == (cfg_swap & ~cfg_async)));

    // R11: reset dominates preset
    p_reset_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_async && is_reg && blk_rst_pt && blk_pre_pt) |=> (q_out == 1'b0));

    // R9: unswapped preset
    p_preset_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_async && is_reg && !cfg_swap && blk_pre_pt && !blk_rst_pt) |=> (q_out == 1'b1));

    // R9: swapped reset term acts as preset
    p_preset_swapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_async && is_reg && cfg_swap && blk_rst_pt && !blk_pre_pt) |=> (q_out == 1'b1));

    // R10: private init as preset
    p_ind_preset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_async && is_reg && ind_init_pt && cfg_init_is_preset) |=> (q_out == 1'b1));

    // R8: combinational pass-through
    p_comb_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_kind == 2'b11) |-> (q_out == d_in));

    // R6: synchronous latch holds with inactive enable
    p_latch_hold_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_kind == 2'b10 && !cfg_async && !(blk_clk[cfg_blk_clk_sel] ^ cfg_clk_inv))
        |=> (q_out == $past(q_out)));

    // R3: asynchronous latch follows the private term clock only
    p_latch_hold_async_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_kind == 2'b10 && cfg_async && !(pt_clk ^ cfg_clk_inv))
        |=> (q_out == $past(q_out)));

    // R5: T register holds with T=0 and no init request
    p_t_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_kind == 2'b01 && !cfg_async && !blk_rst_pt && !blk_pre_pt && !d_in)
        |=> (q_out == $past(q_out)));

endmodule

bind mc_storage_cell mc_storage_chk u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .cfg_async          (cfg_async),
    .cfg_kind           (cfg_kind),
    .cfg_blk_clk_sel    (cfg_blk_clk_sel),
    .cfg_clk_inv        (cfg_clk_inv),
    .cfg_swap           (cfg_swap),
    .cfg_init_is_preset (cfg_init_is_preset),
    .blk_clk            (blk_clk),
    .pt_clk             (pt_clk),
    .blk_rst_pt         (blk_rst_pt),
    .blk_pre_pt         (blk_pre_pt),
    .ind_init_pt        (ind_init_pt),
    .d_in               (d_in),
    .q_out              (q_out)
);

// File: tb/tb_mc_storage_cell.sv
module tb_mc_storage_cell;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_async = 1'b0;
    logic [1:0] cfg_kind = 2'b00;
    logic [1:0] cfg_blk_clk_sel = 2'b00;
    logic       cfg_clk_inv = 1'b0;
    logic       cfg_swap = 1'b0;
    logic       cfg_init_is_preset = 1'b0;
    logic [3:0] blk_clk = 4'h0;
    logic       pt_clk = 1'b0;
    logic       blk_rst_pt = 1'b0;
    logic       blk_pre_pt = 1'b0;
    logic       ind_init_pt = 1'b0;
    logic       d_in = 1'b0;
    logic       q_out;

    int          n_cmp = 0;
    int          n_bad = 0;
    string       cur_tag = "R1";
    logic [15:0] lfsr = 16'hACE1;

    // Behavioural reference state
    logic m_q = 1'b0;
    logic m_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_storage_cell dut (
        .clk(clk), .rst_n(rst_n), .cfg_async(cfg_async), .cfg_kind(cfg_kind),
        .cfg_blk_clk_sel(cfg_blk_clk_sel), .cfg_clk_inv(cfg_clk_inv),
        .cfg_swap(cfg_swap), .cfg_init_is_preset(cfg_init_is_preset),
        .blk_clk(blk_clk), .pt_clk(pt_clk), .blk_rst_pt(blk_rst_pt),
        .blk_pre_pt(blk_pre_pt), .ind_init_pt(ind_init_pt), .d_in(d_in),
        .q_out(q_out)
    );

    // Reference model written from the requirements
    always @(posedge clk) begin : ref_model
        logic lvl, act, rise, clr, set;
        if (!rst_n) begin
            m_q    = (cfg_swap && !cfg_async);
            m_prev = 1'b0;
        end else begin
            lvl  = cfg_async ? pt_clk : blk_clk[cfg_blk_clk_sel];
            act  = lvl ^ cfg_clk_inv;
            rise = act && !m_prev;
            m_prev = act;
            if (cfg_async) begin
                clr = ind_init_pt && !cfg_init_is_preset;
                set = ind_init_pt && cfg_init_is_preset;
            end else begin
                clr = cfg_swap ? blk_pre_pt : blk_rst_pt;
                set = cfg_swap ? blk_rst_pt : blk_pre_pt;
            end
            case (cfg_kind)
                2'b10: if (act) m_q = d_in;
                2'b11: ;
                default: begin
                    if (clr) m_q = 1'b0;
                    else if (set) m_q = 1'b1;
                    else if (rise) m_q = (cfg_kind == 2'b01) ? !m_q : d_in;
                end
            endcase
            if (cfg_kind == 2'b01 && !clr && !set && rise && !d_in) m_q = !m_q;
        end
    end

    task automatic compare();
        logic exp;
        exp = (cfg_kind == 2'b11) ? d_in : m_q;
        n_cmp++;
        if (q_out !== exp) begin
            n_bad++;
            $display("FAIL %s: q_out=%b expected=%b at %0t", cur_tag, q_out, exp, $time);
        end
    endtask

    task automatic shuffle();
        for (int i = 0; i < 7; i++)
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // One cycle: check output, then drive fresh stimulus
    task automatic step(bit init_on, bit both);
        @(negedge clk);
        #1;
        compare();
        shuffle();
        blk_clk = lfsr[3:0];
        pt_clk  = lfsr[4];
        d_in    = lfsr[5];
        if (both) begin
            blk_rst_pt  = lfsr[6];
            blk_pre_pt  = lfsr[6];
            ind_init_pt = 1'b0;
        end else if (init_on) begin
            blk_rst_pt  = (lfsr[9:7] == 3'd0);
            blk_pre_pt  = (lfsr[12:10] == 3'd0);
            ind_init_pt = (lfsr[15:13] == 3'd0);
        end else begin
            blk_rst_pt  = 1'b0;
            blk_pre_pt  = 1'b0;
            ind_init_pt = 1'b0;
        end
    endtask

    task automatic scenario(string tag, logic as, logic [1:0] kind, logic [1:0] sel,
                            logic inv, logic sw, logic ipre, int cycles,
                            bit init_on, bit both);
        cur_tag = "R1";
        rst_n = 1'b0;
        cfg_async = as; cfg_kind = kind; cfg_blk_clk_sel = sel;
        cfg_clk_inv = inv; cfg_swap = sw; cfg_init_is_preset = ipre;
        blk_clk = 4'h0; pt_clk = 1'b0; d_in = 1'b0;
        blk_rst_pt = 1'b0; blk_pre_pt = 1'b0; ind_init_pt = 1'b0;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        rst_n = 1'b1;
        cur_tag = tag;
        for (int c = 0; c < cycles; c++) step(init_on, both);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        // R1: power-up values
        scenario("R1", 1'b0, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0, 2, 1'b0, 1'b0);
        scenario("R1", 1'b0, 2'b00, 2'd0, 1'b0, 1'b1, 1'b0, 2, 1'b0, 1'b0);
        scenario("R1", 1'b1, 2'b01, 2'd0, 1'b0, 1'b1, 1'b0, 2, 1'b0, 1'b0);
        // R2 / R4: each block clock selected for a D register
        for (int s = 0; s < 4; s++)
            scenario("R2", 1'b0, 2'b00, 2'(s), 1'b0, 1'b0, 1'b0, 150, 1'b0, 1'b0);
        scenario("R4", 1'b0, 2'b00, 2'd1, 1'b1, 1'b0, 1'b0, 200, 1'b0, 1'b0);
        // R3: private term clock, both polarities
        scenario("R3", 1'b1, 2'b00, 2'd2, 1'b0, 1'b0, 1'b0, 150, 1'b0, 1'b0);
        scenario("R3", 1'b1, 2'b00, 2'd2, 1'b1, 1'b0, 1'b0, 150, 1'b0, 1'b0);
        // R5: T register
        scenario("R5", 1'b0, 2'b01, 2'd3, 1'b0, 1'b0, 1'b0, 200, 1'b0, 1'b0);
        scenario("R5", 1'b1, 2'b01, 2'd0, 1'b1, 1'b0, 1'b0, 200, 1'b0, 1'b0);
        // R6: latch, both polarities and modes
        scenario("R6", 1'b0, 2'b10, 2'd0, 1'b0, 1'b0, 1'b0, 150, 1'b0, 1'b0);
        scenario("R6", 1'b1, 2'b10, 2'd0, 1'b1, 1'b0, 1'b0, 150, 1'b0, 1'b0);
        // R7: latch with init requests active
        scenario("R7", 1'b0, 2'b10, 2'd2, 1'b0, 1'b1, 1'b0, 200, 1'b1, 1'b0);
        scenario("R7", 1'b1, 2'b10, 2'd2, 1'b0, 1'b0, 1'b1, 200, 1'b1, 1'b0);
        // R8: combinational in both modes
        scenario("R8", 1'b0, 2'b11, 2'd0, 1'b0, 1'b1, 1'b0, 100, 1'b1, 1'b0);
        scenario("R8", 1'b1, 2'b11, 2'd0, 1'b1, 1'b0, 1'b0, 100, 1'b1, 1'b0);
        // R9: block reset/preset, plain and swapped
        scenario("R9", 1'b0, 2'b00, 2'd1, 1'b0, 1'b0, 1'b0, 250, 1'b1, 1'b0);
        scenario("R9", 1'b0, 2'b01, 2'd1, 1'b0, 1'b1, 1'b0, 250, 1'b1, 1'b0);
        // R10: private init term as reset and as preset
        scenario("R10", 1'b1, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0, 250, 1'b1, 1'b0);
        scenario("R10", 1'b1, 2'b01, 2'd0, 1'b0, 1'b0, 1'b1, 250, 1'b1, 1'b0);
        // R11: reset and preset together
        scenario("R11", 1'b0, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0, 150, 1'b0, 1'b1);
        scenario("R11", 1'b0, 2'b01, 2'd0, 1'b0, 1'b1, 1'b0, 150, 1'b0, 1'b1);
        step(1'b0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule